// File: doc/BRIEF.md
# Step-Programmable Terminal Count Counter

This block is a synchronous counter whose step, direction, terminal value and output width are all fixed when the design is elaborated. On every enabled rising clock edge the count moves up or down by the step and wraps modulo 2^WIDTH. A one-bit flag reports, in the same cycle, whether the registered count equals the terminal value.

A parameter can turn on auto-clear. In that mode the count returns to zero on the enabled edge that follows a cycle in which the flag was high. This lets the block serve as a programmable period or timeout generator without any extra compare logic around it.

The block has two resets. An active-low asynchronous reset handles power-up. An active-high synchronous clear serves the functional datapath, and it wins over the clock enable.

Top module: `tc_step_counter`

## Requirements
- R1: While `rst_n` is low, `count_o` is zero at once, with no clock edge needed.
- R2: When `srst` is high at a rising edge, the count becomes zero whatever the state of `en`.
- R3: When `en` and `srst` are both low at a rising edge, the count keeps its value.
- R4: With DIR = CNT_UP (encoding 0), each enabled edge loads (count + STEP) mod 2^WIDTH.
- R5: With DIR = CNT_DOWN (encoding 1), each enabled edge loads (count - STEP) mod 2^WIDTH.
- R6: Only the low WIDTH bits of STEP and TC_VALUE take effect. The higher bits are ignored.
- R7: `tc_o` is high in exactly those cycles where `count_o` equals the low WIDTH bits of TC_VALUE. It is decoded from the registered count, with no added delay.
- R8: With AUTO_CLEAR = 1, an enabled edge that finds `tc_o` high loads zero instead of stepping. With AUTO_CLEAR = 0, the count steps past the terminal value as usual.
- R9: When the truncated TC_VALUE is zero, `tc_o` is high in the first cycle after a reset or a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srst | input | 1 | Synchronous active-high clear, takes priority over `en` |
| en | input | 1 | Active-high count enable |
| count_o | output | WIDTH | Registered count value |
| tc_o | output | 1 | High while the count equals the terminal value |

## Verification
Several behaviours are checked by assertions on every cycle:
- the hold when the counter is idle,
- the clear through `srst`,
- the up or down step chosen by DIR,
- the zero load in auto-clear mode,
- the flag after a clear when the terminal value is zero.

Other behaviours only the bench scenarios can show. These are the immediate effect of the asynchronous reset, the truncation of wide step and terminal values, and the exact wrap sequence. The bench shows them by running five configurations side by side (4-bit up, 4-bit down, 4-bit auto-clear, 1-bit auto-clear and 48-bit default) against an arithmetic model.

// File: rtl/tc_step_pkg.sv
package tc_step_pkg;
  typedef enum logic {
    CNT_UP   = 1'b0,
    CNT_DOWN = 1'b1
  } cnt_dir_e;

  localparam int unsigned MAX_W = 48;
endpackage

// File: rtl/tc_step_next.sv
module tc_step_next #(
  parameter int unsigned            WIDTH = 48,
  parameter logic [47:0]            STEP  = 48'h1,
  parameter tc_step_pkg::cnt_dir_e  DIR   = tc_step_pkg::CNT_UP
) (
  input  logic [WIDTH-1:0] cur_i,
  output logic [WIDTH-1:0] stepped_o
);
  localparam logic [WIDTH-1:0] STEP_T = STEP[WIDTH-1:0];

  generate
    if (DIR == tc_step_pkg::CNT_UP) begin : g_up
      always_comb stepped_o = cur_i + STEP_T;
    end else begin : g_down
      always_comb stepped_o = cur_i - STEP_T;
    end
  endgenerate
endmodule

// File: rtl/tc_step_match.sv
module tc_step_match #(
  parameter int unsigned WIDTH    = 48,
  parameter logic [47:0] TC_VALUE = 48'h0
) (
  input  logic [WIDTH-1:0] cur_i,
  output logic             hit_o
);
  localparam logic [WIDTH-1:0] TC_T = TC_VALUE[WIDTH-1:0];

  always_comb hit_o = (cur_i == TC_T);
endmodule

// File: rtl/tc_step_counter.sv
module tc_step_counter #(
  parameter int unsigned           WIDTH      = 48,
  parameter logic [47:0]           STEP       = 48'h1,
  parameter logic [47:0]           TC_VALUE   = 48'h0,
  parameter tc_step_pkg::cnt_dir_e DIR        = tc_step_pkg::CNT_UP,
  parameter bit                    AUTO_CLEAR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             en,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  localparam logic [WIDTH-1:0] STEP_T = STEP[WIDTH-1:0];
  localparam logic [WIDTH-1:0] TC_T   = TC_VALUE[WIDTH-1:0];
  localparam bit               TC_ZERO = (TC_T == '0);

  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;
  logic [WIDTH-1:0] stepped;
  logic             tc_hit;
  logic             wrap_clr;

  tc_step_next #(
    .WIDTH (WIDTH),
    .STEP  (STEP),
    .DIR   (DIR)
  ) u_next (
    .cur_i     (count_q),
    .stepped_o (stepped)
  );

  tc_step_match #(
    .WIDTH    (WIDTH),
    .TC_VALUE (TC_VALUE)
  ) u_match (
    .cur_i (count_q),
    .hit_o (tc_hit)
  );

  generate
    if (AUTO_CLEAR) begin : g_autoclr
      always_comb wrap_clr = tc_hit;
    end else begin : g_noclr
      always_comb wrap_clr = 1'b0;
    end
  endgenerate

  // next-state selection: clear beats enable, auto-clear beats step
  always_comb begin
    count_d = count_q;
    if (srst) begin
      count_d = '0;
    end else if (en) begin
      if (wrap_clr) begin
        count_d = '0;
      end else begin
        count_d = stepped;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;
  assign tc_o    = tc_hit;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !srst) |=> $stable(count_o)); // R3

  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (count_o == '0)); // R2

  generate
    if (DIR == tc_step_pkg::CNT_UP) begin : g_ast_up
      AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !srst && !(AUTO_CLEAR && tc_o))
          |=> (count_o == WIDTH'($past(count_o) + STEP_T))); // R4
    end else begin : g_ast_dn
      AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !srst && !(AUTO_CLEAR && tc_o))
          |=> (count_o == WIDTH'($past(count_o) - STEP_T))); // R5
    end
    if (AUTO_CLEAR) begin : g_ast_ac
      AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !srst && tc_o) |=> (count_o == '0)); // R8
    end
    if (TC_ZERO) begin : g_ast_tz
      AST_TC_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> tc_o); // R9
    end
  endgenerate
endmodule

// File: tb/tc_step_counter_tb.sv
module tc_step_counter_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic srst;
  logic en;

  logic [3:0]  qa, qb, qc;
  logic [0:0]  qd;
  logic [47:0] qe;
  logic [N-1:0] tcv;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // A: 4-bit up, wide step/tc truncated (R6); B: 4-bit down; C: 4-bit auto-clear;
  // D: 1-bit auto-clear; E: 48-bit default
  tc_step_counter #(.WIDTH(4), .STEP(48'h13), .TC_VALUE(48'h25),
    .DIR(tc_step_pkg::CNT_UP), .AUTO_CLEAR(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .srst(srst), .en(en), .count_o(qa), .tc_o(tcv[0]));
  tc_step_counter #(.WIDTH(4), .STEP(48'h1), .TC_VALUE(48'h0),
    .DIR(tc_step_pkg::CNT_DOWN), .AUTO_CLEAR(1'b0)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .srst(srst), .en(en), .count_o(qb), .tc_o(tcv[1]));
  tc_step_counter #(.WIDTH(4), .STEP(48'h2), .TC_VALUE(48'h6),
    .DIR(tc_step_pkg::CNT_UP), .AUTO_CLEAR(1'b1)) u_dut_c (
    .clk(clk), .rst_n(rst_n), .srst(srst), .en(en), .count_o(qc), .tc_o(tcv[2]));
  tc_step_counter #(.WIDTH(1), .STEP(48'h1), .TC_VALUE(48'h1),
    .DIR(tc_step_pkg::CNT_UP), .AUTO_CLEAR(1'b1)) u_dut_d (
    .clk(clk), .rst_n(rst_n), .srst(srst), .en(en), .count_o(qd), .tc_o(tcv[3]));
  tc_step_counter u_dut_e (
    .clk(clk), .rst_n(rst_n), .srst(srst), .en(en), .count_o(qe), .tc_o(tcv[4]));

  int          cfg_w  [N] = '{4, 4, 4, 1, 48};
  logic [47:0] cfg_st [N] = '{48'h13, 48'h1, 48'h2, 48'h1, 48'h1};
  logic [47:0] cfg_tv [N] = '{48'h25, 48'h0, 48'h6, 48'h1, 48'h0};
  bit          cfg_dn [N] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
  bit          cfg_ac [N] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  string       cfg_rq [N] = '{"R4/R6", "R5", "R8", "R8", "R4"};

  logic [47:0] act [N];
  logic [47:0] exp_q [N];

  always_comb begin
    act[0] = {44'b0, qa};
    act[1] = {44'b0, qb};
    act[2] = {44'b0, qc};
    act[3] = {47'b0, qd};
    act[4] = qe;
  end

  function automatic logic [47:0] mask_of(input int w);
    return (w >= 48) ? {48{1'b1}} : ((48'd1 << w) - 48'd1);
  endfunction

  function automatic logic [47:0] model(input int i, input logic [47:0] c,
                                        input bit e, input bit s);
    logic [47:0] m;
    m = mask_of(cfg_w[i]);
    if (s) return '0;
    if (!e) return c;
    if (cfg_ac[i] && (c == (cfg_tv[i] & m))) return '0;
    return cfg_dn[i] ? ((c - cfg_st[i]) & m) : ((c + cfg_st[i]) & m);
  endfunction

  task automatic chk_all(input string tag);
    for (int i = 0; i < N; i++) begin
      logic exp_tc;
      exp_tc = (exp_q[i] == (cfg_tv[i] & mask_of(cfg_w[i])));
      checks++;
      if (act[i] !== exp_q[i]) begin
        failures++;
        $display("FAIL %s %s dut%0d count act=%0h exp=%0h", tag, cfg_rq[i], i, act[i], exp_q[i]);
      end
      checks++;
      if (tcv[i] !== exp_tc) begin
        failures++;
        $display("FAIL R7 %s dut%0d tc act=%0b exp=%0b", tag, i, tcv[i], exp_tc);
      end
    end
  endtask

  task automatic cyc(input bit e, input bit s, input string tag);
    en   = e;
    srst = s;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) exp_q[i] = model(i, exp_q[i], e, s);
    chk_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    srst  = 1'b0;
    en    = 1'b0;
    for (int i = 0; i < N; i++) exp_q[i] = '0;
    repeat (2) @(negedge clk);
    chk_all("R1 reset state, R9 flag at zero");
    rst_n = 1'b1;

    // free running: wrap, truncation, auto-clear
    for (int k = 0; k < 40; k++) cyc(1'b1, 1'b0, "R4 R5 R6 R8 run");

    // gated enable pattern
    for (int k = 0; k < 30; k++) cyc((k % 3) == 0, 1'b0, "R3 gated enable");

    // clear with enable high, then check flag right after
    for (int k = 0; k < 5; k++) cyc(1'b1, 1'b0, "R4 pre-clear");
    cyc(1'b1, 1'b1, "R2 R9 clear over enable");
    cyc(1'b0, 1'b1, "R2 clear while idle");
    for (int k = 0; k < 7; k++) cyc(1'b1, 1'b0, "R8 post-clear run");

    // asynchronous reset in mid-count, no clock edge
    #1;
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < N; i++) exp_q[i] = '0;
    chk_all("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 20; k++) cyc(k != 4, 1'b0, "R3 R4 R5 after async reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule